// File: doc/BRIEF.md
# Multiplexed Latching Bus Transceiver

This block links one 12-bit port A with two 12-bit banks, B1 and B2, in both directions. Going from A towards the banks, the shared A bus feeds two latches, one per bank. Each latch opens and closes on its own enable. This lets successive words on A, such as an address and then a data word, be split onto the two banks. Going from the banks towards A, each bank has its own input latch. A select line picks which latched bank value is presented on A.

Every port is bidirectional. A pin is modelled as a value input with an external-drive flag, plus a data output with a drive-enable. Each input has a keeper. While nothing drives a bus, the keeper supplies the last value that was driven onto it. The keeper samples on the clock and resets asynchronously to zero. The latches themselves are level-sensitive and have no clock.

Top module: `mux_latch_xcvr`

## Requirements
- R1: Each of the four latches (A to B1, A to B2, B1 to A, B2 to A) is transparent while its enable is 1, so its output follows its input.
- R2: When a latch enable is 0, that latch keeps the value it had when the enable fell, whatever its input does.
- R3: With `sel_b1` = 1, port A carries the B1-to-A latch value; with `sel_b1` = 0, it carries the B2-to-A latch value.
- R4: `oe_a_n` is active low. When it is 1, `a_drv` is 0 and `a_out` is all zeros. When it is 0, `a_drv` is 1.
- R5: `oe_b1_n` and `oe_b2_n` are active low and gate only their own bank: a disabled bank shows drive-enable 0 and data all zeros, while the other bank is unaffected.
- R6: While a port's external-drive flag is 0, the value seen inside the block for that port is the value that was present at the last rising clock edge with the flag at 1. Changes on the undriven pin are ignored.
- R7: While `rst_n` is 0, every keeper holds zero. An undriven port behind a transparent latch therefore shows zero.
- R8: The A-to-B1 and A-to-B2 latches are independent, so two different values seen on A in turn can be held on the two banks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the keepers |
| rst_n | input | 1 | Asynchronous active-low reset of the keepers |
| a_in | input | 12 | Value on the A pins |
| a_ext_drv | input | 1 | 1 when an external agent drives A |
| b1_in | input | 12 | Value on the B1 pins |
| b1_ext_drv | input | 1 | 1 when an external agent drives B1 |
| b2_in | input | 12 | Value on the B2 pins |
| b2_ext_drv | input | 1 | 1 when an external agent drives B2 |
| le_ab1 | input | 1 | Enable of the A-to-B1 latch |
| le_ab2 | input | 1 | Enable of the A-to-B2 latch |
| le_b1a | input | 1 | Enable of the B1-to-A latch |
| le_b2a | input | 1 | Enable of the B2-to-A latch |
| sel_b1 | input | 1 | 1 routes B1 path to A, 0 routes B2 path |
| oe_a_n | input | 1 | Active-low output enable of A |
| oe_b1_n | input | 1 | Active-low output enable of B1 |
| oe_b2_n | input | 1 | Active-low output enable of B2 |
| a_out | output | 12 | Data driven onto A |
| a_drv | output | 1 | Drive-enable of A |
| b1_out | output | 12 | Data driven onto B1 |
| b1_drv | output | 1 | Drive-enable of B1 |
| b2_out | output | 12 | Data driven onto B2 |
| b2_drv | output | 1 | Drive-enable of B2 |

## Verification
The hardest condition to reach from the ports is a keeper supplying a value after its bus has been released. That value must then pass through a transparent latch to an enabled output. The bench drives B1 with a known word across a rising edge and releases it at the next falling edge. It then scrambles `b1_in` while the B1-to-A latch stays open and `sel_b1` is 1. Port A must keep showing the released word. The reset state is reached the same way: all latches are left open with nothing driven, and the outputs must show the zeros held in the keepers.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned NUM_LATCH = 4;
  localparam int unsigned P_A  = 0;
  localparam int unsigned P_B1 = 1;
  localparam int unsigned P_B2 = 2;
  localparam int unsigned L_AB1 = 0;
  localparam int unsigned L_AB2 = 1;
  localparam int unsigned L_B1A = 2;
  localparam int unsigned L_B2A = 3;
endpackage

// File: rtl/mlx_keeper.sv
module mlx_keeper #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic         drive_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (drive_i) held_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (drive_i) held_q <= held_d;
  end

  assign value_o = drive_i ? pin_i : held_q;

  assert_keeper_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_i) |=> $stable(held_q));
  assert_keeper_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_i) |-> (value_o == held_q));
endmodule

// File: rtl/mlx_latch.sv
module mlx_latch #(
  parameter int unsigned W = 12
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/mux_latch_xcvr.sv
module mux_latch_xcvr
  import mlx_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_ext_drv,
  input  logic [W-1:0] b1_in,
  input  logic         b1_ext_drv,
  input  logic [W-1:0] b2_in,
  input  logic         b2_ext_drv,
  input  logic         le_ab1,
  input  logic         le_ab2,
  input  logic         le_b1a,
  input  logic         le_b2a,
  input  logic         sel_b1,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  output logic [W-1:0] b2_out,
  output logic         b2_drv
);
  logic [W-1:0] pin_in   [NUM_PORTS];
  logic         pin_ext  [NUM_PORTS];
  logic [W-1:0] kept     [NUM_PORTS];
  logic [W-1:0] lat_d    [NUM_LATCH];
  logic [W-1:0] lat_q    [NUM_LATCH];
  logic [NUM_LATCH-1:0] lat_en;
  logic [W-1:0] a_sel;

  assign pin_in[P_A]   = a_in;
  assign pin_in[P_B1]  = b1_in;
  assign pin_in[P_B2]  = b2_in;
  assign pin_ext[P_A]  = a_ext_drv;
  assign pin_ext[P_B1] = b1_ext_drv;
  assign pin_ext[P_B2] = b2_ext_drv;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_keep
    mlx_keeper #(.W(W)) u_keep (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in[p]),
      .drive_i(pin_ext[p]), .value_o(kept[p])
    );
  end

  assign lat_en[L_AB1] = le_ab1;
  assign lat_en[L_AB2] = le_ab2;
  assign lat_en[L_B1A] = le_b1a;
  assign lat_en[L_B2A] = le_b2a;
  assign lat_d[L_AB1]  = kept[P_A];
  assign lat_d[L_AB2]  = kept[P_A];
  assign lat_d[L_B1A]  = kept[P_B1];
  assign lat_d[L_B2A]  = kept[P_B2];

  for (genvar l = 0; l < NUM_LATCH; l++) begin : g_lat
    mlx_latch #(.W(W)) u_lat (.en_i(lat_en[l]), .d_i(lat_d[l]), .q_o(lat_q[l]));
  end

  assign a_sel  = sel_b1 ? lat_q[L_B1A] : lat_q[L_B2A];
  assign a_drv  = !oe_a_n;
  assign b1_drv = !oe_b1_n;
  assign b2_drv = !oe_b2_n;
  assign a_out  = a_drv  ? a_sel        : '0;
  assign b1_out = b1_drv ? lat_q[L_AB1] : '0;
  assign b2_out = b2_drv ? lat_q[L_AB2] : '0;

  assert_open_ab1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab1 |-> (lat_q[L_AB1] == kept[P_A]));
  assert_open_b2a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    le_b2a |-> (lat_q[L_B2A] == kept[P_B2]));
  assert_hold_ab2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab2 && $past(!le_ab2)) |-> $stable(lat_q[L_AB2]));
  assert_hold_b1a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_b1a && $past(!le_b1a)) |-> $stable(lat_q[L_B1A]));
  assert_steer_b1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv && sel_b1) |-> (a_out == lat_q[L_B1A]));
  assert_quiet_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_a_n |-> (!a_drv && a_out == '0));
  assert_quiet_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b1_n |-> b1_out == '0) and (oe_b2_n |-> b2_out == '0));
endmodule

// File: tb/test_mux_latch_xcvr.sv
module test_mux_latch_xcvr;
  localparam int unsigned W = 12;

  typedef struct packed {
    logic [11:0] a, b1, b2;
    logic [3:0]  le;    // {ab1, ab2, b1a, b2a}
    logic        sel;
    logic [2:0]  oen;   // {a, b1, b2}
    logic [11:0] ea, eb1, eb2;
    logic [2:0]  edrv;  // {a, b1, b2}
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{12'h111, 12'h222, 12'h333, 4'b1111, 1'b1, 3'b000, 12'h222, 12'h111, 12'h111, 3'b111},
    '{12'h444, 12'h555, 12'h666, 4'b0111, 1'b0, 3'b000, 12'h666, 12'h111, 12'h444, 3'b111},
    '{12'h777, 12'h888, 12'h999, 4'b0000, 1'b1, 3'b000, 12'h555, 12'h111, 12'h444, 3'b111},
    '{12'h777, 12'h888, 12'h999, 4'b0000, 1'b0, 3'b100, 12'h000, 12'h111, 12'h444, 3'b011},
    '{12'h777, 12'h888, 12'h999, 4'b0000, 1'b0, 3'b010, 12'h666, 12'h000, 12'h444, 3'b101},
    '{12'habc, 12'h888, 12'h999, 4'b1000, 1'b0, 3'b001, 12'h666, 12'habc, 12'h000, 3'b110},
    '{12'h0f0, 12'h888, 12'hdef, 4'b0001, 1'b0, 3'b000, 12'hdef, 12'habc, 12'h444, 3'b111},
    '{12'h0f0, 12'h123, 12'hdef, 4'b0010, 1'b1, 3'b000, 12'h123, 12'habc, 12'h444, 3'b111}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic a_ext_drv, b1_ext_drv, b2_ext_drv;
  logic le_ab1, le_ab2, le_b1a, le_b2a, sel_b1, oe_a_n, oe_b1_n, oe_b2_n;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_latch_xcvr #(.W(W)) i_mux_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_ext_drv(a_ext_drv),
    .b1_in(b1_in), .b1_ext_drv(b1_ext_drv),
    .b2_in(b2_in), .b2_ext_drv(b2_ext_drv),
    .le_ab1(le_ab1), .le_ab2(le_ab2), .le_b1a(le_b1a), .le_b2a(le_b2a),
    .sel_b1(sel_b1), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
    .a_out(a_out), .a_drv(a_drv), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_out(b2_out), .b2_drv(b2_drv)
  );

  task automatic chk(input string req, input int idx, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step %0d: actual %h expected %h", req, idx, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_in = '1; b1_in = '1; b2_in = '1;
    a_ext_drv = 1'b0; b1_ext_drv = 1'b0; b2_ext_drv = 1'b0;
    {le_ab1, le_ab2, le_b1a, le_b2a} = 4'b1111;
    sel_b1 = 1'b1;
    {oe_a_n, oe_b1_n, oe_b2_n} = 3'b000;
    repeat (3) @(negedge clk);
    #1;
    // R7: undriven inputs show keeper zero through open latches
    chk("R7 a_out", 0, a_out, '0);
    chk("R7 b1_out", 0, b1_out, '0);
    chk("R7 b2_out", 0, b2_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R1 R2 R3 R4 R5 R8
    a_ext_drv = 1'b1; b1_ext_drv = 1'b1; b2_ext_drv = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_in = VECS[i].a; b1_in = VECS[i].b1; b2_in = VECS[i].b2;
      {le_ab1, le_ab2, le_b1a, le_b2a} = VECS[i].le;
      sel_b1 = VECS[i].sel;
      {oe_a_n, oe_b1_n, oe_b2_n} = VECS[i].oen;
      #1;
      chk("R1/R2/R3/R4 a_out", i, a_out, VECS[i].ea);
      chk("R1/R2/R5/R8 b1_out", i, b1_out, VECS[i].eb1);
      chk("R1/R2/R5/R8 b2_out", i, b2_out, VECS[i].eb2);
      chk("R4/R5 drive flags", i, {9'd0, a_drv, b1_drv, b2_drv}, {9'd0, VECS[i].edrv});
    end

    // R6: keeper retains released B1 value behind an open latch
    @(negedge clk);
    {le_ab1, le_ab2, le_b1a, le_b2a} = 4'b0010;
    sel_b1 = 1'b1;
    {oe_a_n, oe_b1_n, oe_b2_n} = 3'b000;
    b1_in = 12'h5a5;
    @(negedge clk);
    b1_ext_drv = 1'b0;
    b1_in = 12'hfff;
    #1;
    chk("R6 released", 100, a_out, 12'h5a5);
    @(negedge clk);
    b1_in = 12'h00f;
    repeat (2) @(negedge clk);
    #1;
    chk("R6 ignored", 101, a_out, 12'h5a5);
    // R6: redriving updates again
    b1_ext_drv = 1'b1;
    b1_in = 12'h3c3;
    #1;
    chk("R6 redriven", 102, a_out, 12'h3c3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule